// File: doc/BRIEF.md
# Segment Offset Translator with Limit Check

This block turns an offset inside a memory segment into a linear address and checks whether the offset lies inside the segment. It holds one segment descriptor, which has a base, a limit and a direction flag. The flag selects between a segment that grows upward from its base and one that grows downward. A load strobe replaces the whole descriptor in a single cycle.

Each request is an offset with a valid strobe. One clock later the block returns a linear address, a fault bit and a result-valid strobe. Both directions use the same adder, which computes base plus offset modulo 2^WIDTH. Only the legality test changes with the direction. In a downward segment the legal offsets are the large ones, and because the sum wraps, the resulting addresses fall below the base.

The result stage is a two-state machine. `RS_IDLE` means no result is presented. `RS_EMIT` means a result is presented this cycle. Transitions:
- `IDLE_TO_EMIT` on a valid request.
- `EMIT_HOLD` when valid requests arrive back to back.
- `EMIT_TO_IDLE` when no request arrives.
- Reset forces `RS_IDLE`.

Top module: `seg_xlat`

## Requirements
- R1: The linear address of an accepted request is (base + offset) mod 2^WIDTH, with the carry discarded, in both directions. For example, base 0xF000 plus offset 0x2000 gives 0x1000.
- R2: With the direction flag low (upward), the fault bit is 1 exactly when offset > limit. An offset equal to the limit is legal.
- R3: With the direction flag high (downward), the fault bit is 1 exactly when offset <= limit. Legal offsets run from limit+1 to 2^WIDTH-1.
- R4: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low after a cycle without one. Back-to-back requests give back-to-back results in order.
- R5: Whenever a result carries the fault bit, `rsp_addr` is zero.
- R6: `desc_load` captures base, limit and the direction flag together at the clock edge. A request in the same cycle as the load is judged against the previous descriptor.
- R7: Synchronous active-high reset sets base 0, limit all ones and upward direction, and drives `rsp_valid` low.
- R8: With WIDTH 16, an upward segment with base 0x1000 and limit 0x100 maps offset 0x10 to 0x1010 without a fault. A downward segment with base 0x1000 and limit 0xFEFF maps offset 0xFFEF to 0x0FEF without a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Capture a new descriptor this cycle |
| desc_base | input | WIDTH | Base for the new descriptor |
| desc_limit | input | WIDTH | Limit for the new descriptor |
| desc_down | input | 1 | Direction of the new descriptor: 1 downward, 0 upward |
| req_valid | input | 1 | Offset request strobe |
| req_offset | input | WIDTH | Offset within the segment |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | WIDTH | Linear address, zero on a fault |
| rsp_fault | output | 1 | Limit violation |

## Verification
The assertions assume that `req_valid`, `req_offset` and the descriptor inputs are stable and known at each rising edge. They also assume that `req_valid` stays low throughout reset, so that `$past` of a request never refers to a value sampled during reset. The bench changes every input only on the falling clock edge and holds `req_valid` low until reset is released. It also loads descriptors in cycles that both carry and lack requests, so that the old-descriptor rule of R6 is exercised.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } seg_dir_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_EMIT = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/seg_desc_reg.sv
module seg_desc_reg
    import seg_xlat_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] new_base,
    input  logic [WIDTH-1:0] new_limit,
    input  logic             new_down,
    output logic [WIDTH-1:0] cur_base,
    output logic [WIDTH-1:0] cur_limit,
    output seg_dir_e         cur_dir
);

    // All three fields move together so a descriptor is never half-updated.
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_base  <= '0;
            cur_limit <= '1;
            cur_dir   <= DIR_UP;
        end else if (load) begin
            cur_base  <= new_base;
            cur_limit <= new_limit;
            cur_dir   <= new_down ? DIR_DOWN : DIR_UP;
        end
    end

endmodule

// File: rtl/seg_limit_chk.sv
module seg_limit_chk
    import seg_xlat_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] offset,
    input  logic [WIDTH-1:0] limit,
    input  seg_dir_e         dir,
    output logic             fault
);

    logic beyond;

    // One magnitude compare; the direction only picks its polarity.
    always_comb begin
        beyond = (offset > limit);
        unique case (dir)
            DIR_UP:   fault = beyond;
            DIR_DOWN: fault = !beyond;
            default:  fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_addr_add.sv
module seg_addr_add #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] base,
    input  logic [WIDTH-1:0] offset,
    output logic [WIDTH-1:0] sum
);

    logic [WIDTH:0] full;

    // Carry bit is dropped: the wraparound is what places downward
    // segments below their base.
    always_comb begin
        full = {1'b0, base} + {1'b0, offset};
        sum  = full[WIDTH-1:0];
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             desc_load,
    input  logic [WIDTH-1:0] desc_base,
    input  logic [WIDTH-1:0] desc_limit,
    input  logic             desc_down,
    input  logic             req_valid,
    input  logic [WIDTH-1:0] req_offset,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_addr,
    output logic             rsp_fault
);

    logic [WIDTH-1:0] dsc_base;
    logic [WIDTH-1:0] dsc_limit;
    seg_dir_e         dsc_dir;
    logic [WIDTH-1:0] lin_sum;
    logic             lim_fault;
    rsp_state_e       state_q;
    rsp_state_e       state_d;

    seg_desc_reg #(.WIDTH(WIDTH)) u_desc (
        .clk       (clk),
        .rst       (rst),
        .load      (desc_load),
        .new_base  (desc_base),
        .new_limit (desc_limit),
        .new_down  (desc_down),
        .cur_base  (dsc_base),
        .cur_limit (dsc_limit),
        .cur_dir   (dsc_dir)
    );

    seg_addr_add #(.WIDTH(WIDTH)) u_add (
        .base   (dsc_base),
        .offset (req_offset),
        .sum    (lin_sum)
    );

    seg_limit_chk #(.WIDTH(WIDTH)) u_chk (
        .offset (req_offset),
        .limit  (dsc_limit),
        .dir    (dsc_dir),
        .fault  (lim_fault)
    );

    // Next-state logic of the result stage.
    always_comb begin
        unique case (state_q)
            RS_IDLE: state_d = req_valid ? RS_EMIT : RS_IDLE;  // IDLE_TO_EMIT
            RS_EMIT: state_d = req_valid ? RS_EMIT : RS_IDLE;  // EMIT_HOLD / EMIT_TO_IDLE
            default: state_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RS_IDLE;
        else     state_q <= state_d;
    end

    // Result payload; a faulting access never exposes an address.
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_addr  <= '0;
            rsp_fault <= 1'b0;
        end else if (req_valid) begin
            rsp_addr  <= lim_fault ? '0 : lin_sum;
            rsp_fault <= lim_fault;
        end
    end

    assign rsp_valid = (state_q == RS_EMIT);

endmodule

// File: rtl/seg_xlat_checker.sv
module seg_xlat_checker
    import seg_xlat_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [WIDTH-1:0] req_offset,
    input logic [WIDTH-1:0] cur_base,
    input logic [WIDTH-1:0] cur_limit,
    input seg_dir_e         cur_dir,
    input logic             rsp_valid,
    input logic [WIDTH-1:0] rsp_addr,
    input logic             rsp_fault
);

    p_addr_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_fault ->
            rsp_addr == WIDTH'($past(cur_base) + $past(req_offset))));

    p_up_limit_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_dir == DIR_UP) |=>
            (rsp_fault == ($past(req_offset) > $past(cur_limit))));

    p_down_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_dir == DIR_DOWN) |=>
            (rsp_fault == ($past(req_offset) <= $past(cur_limit))));

    p_valid_follows_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_valid_drops_r4: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

endmodule

bind seg_xlat seg_xlat_checker #(.WIDTH(WIDTH)) u_seg_xlat_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .cur_base   (dsc_base),
    .cur_limit  (dsc_limit),
    .cur_dir    (dsc_dir),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_fault  (rsp_fault)
);

// File: tb/seg_xlat_test.sv
module seg_xlat_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         desc_load = 1'b0;
    logic [W-1:0] desc_base = '0;
    logic [W-1:0] desc_limit = '0;
    logic         desc_down = 1'b0;
    logic         req_valid = 1'b0;
    logic [W-1:0] req_offset = '0;
    logic         rsp_valid;
    logic [W-1:0] rsp_addr;
    logic         rsp_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench's own view of the loaded descriptor.
    logic [W-1:0] m_base  = '0;
    logic [W-1:0] m_limit = '1;
    logic         m_down  = 1'b0;

    logic [W-1:0] q_addr[$];
    logic         q_fault[$];
    string        q_tag[$];

    seg_xlat #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .desc_load(desc_load), .desc_base(desc_base),
        .desc_limit(desc_limit), .desc_down(desc_down), .req_valid(req_valid),
        .req_offset(req_offset), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault)
    );

    always #5 clk = ~clk;

    task automatic push_expect(input logic [W-1:0] off, input string tag);
        logic f;
        logic [W:0] s;
        f = m_down ? (off <= m_limit) : (off > m_limit);
        s = {1'b0, m_base} + {1'b0, off};
        q_addr.push_back(f ? '0 : s[W-1:0]);
        q_fault.push_back(f);
        q_tag.push_back(tag);
    endtask

    // Drive one request for one cycle, optionally with a load in the same cycle.
    task automatic step(input bit req, input logic [W-1:0] off, input string tag,
                        input bit ld, input logic [W-1:0] b, input logic [W-1:0] l,
                        input bit dn);
        @(negedge clk);
        req_valid  = req;
        req_offset = off;
        desc_load  = ld;
        desc_base  = b;
        desc_limit = l;
        desc_down  = dn;
        if (req) push_expect(off, tag);   // judged with the old descriptor (R6)
        if (ld) begin
            m_base = b; m_limit = l; m_down = dn;
        end
    endtask

    task automatic send(input logic [W-1:0] off, input string tag);
        step(1'b1, off, tag, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic load(input logic [W-1:0] b, input logic [W-1:0] l, input bit dn);
        step(1'b0, '0, "", 1'b1, b, l, dn);
    endtask

    task automatic idle();
        step(1'b0, '0, "", 1'b0, '0, '0, 1'b0);
    endtask

    // Monitor: compare each result against the front of the queue.
    always @(negedge clk) begin
        if (!rst && !done && rsp_valid) begin
            checks++;
            if (q_addr.size() == 0) begin
                fails++;
                $display("FAIL R4: unexpected result addr=%h fault=%0b expected no result",
                         rsp_addr, rsp_fault);
            end else begin
                logic [W-1:0] ea;
                logic ef;
                string t;
                ea = q_addr.pop_front();
                ef = q_fault.pop_front();
                t  = q_tag.pop_front();
                if (rsp_addr !== ea || rsp_fault !== ef) begin
                    fails++;
                    $display("FAIL %s: addr=%h fault=%0b expected addr=%h fault=%0b",
                             t, rsp_addr, rsp_fault, ea, ef);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R7: rsp_valid=%0b expected 0 after reset", rsp_valid);
        end
        // R7: reset descriptor is base 0, limit all ones, upward.
        send(16'hFFFF, "R7");
        send(16'h0000, "R7");
        idle();

        // R8 / R2 / R5: upward segment
        load(16'h1000, 16'h0100, 1'b0);
        send(16'h0010, "R8");
        send(16'h0100, "R2");   // equal to limit: legal
        send(16'h0101, "R2");   // one past: fault, address zero
        idle();
        send(16'hFFFF, "R5");
        idle(); idle();

        // R1: wraparound in an upward segment
        load(16'hF000, 16'hFFFF, 1'b0);
        send(16'h2000, "R1");
        send(16'h0FFF, "R1");

        // R8 / R3: downward segment
        load(16'h1000, 16'hFEFF, 1'b1);
        send(16'hFFEF, "R8");
        send(16'hFEFF, "R3");   // equal to limit: fault
        send(16'hFF00, "R3");   // limit+1: legal
        send(16'hFFFF, "R3");
        send(16'h0000, "R3");
        idle();

        // R6: load and request in the same cycle; request sees old descriptor.
        step(1'b1, 16'h0005, "R6", 1'b1, 16'h0000, 16'h0010, 1'b0);
        send(16'h0005, "R6");
        send(16'h0011, "R6");

        // R4: gaps between requests
        idle();
        send(16'h0003, "R4");
        idle(); idle();
        send(16'h0010, "R4");
        idle(); idle(); idle();

        done = 1;
        checks++;
        if (q_addr.size() != 0) begin
            fails++;
            $display("FAIL R4: %0d results missing, expected 0", q_addr.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule